// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

An N x N grid of signed multiply-accumulate cells. Every cell keeps one weight while activation values march through it from left to right. Each column is dedicated to one filter. Its weights enter at the top edge and shift downward until the column is full. A swap command then makes the loaded set live in every cell on a single clock edge.

Activation vectors arrive on the left edge, one element per row, and are accepted on any cycle that `act_valid_i` is high. The grid skews them internally so that row r runs r cycles behind row 0. Partial sums travel down each column, one row per cycle, and leave at the bottom as the dot product of the vector with that column's weights.

Each cell has a second, shadow weight register. The next weight set can therefore shift in while the current set is still computing, and it stays invisible until the next accepted swap.

Top module: `ws_systolic_grid`

## Requirements
- R1: While reset is held and after it is released, `col_valid_o`, `done_o` and `err_o` are 0, and every live and shadow weight is 0. Vectors streamed before any swap therefore produce 0 in every column.
- R2: Each cycle with `wload_i` high shifts the shadow weights of every column down one row, and `wdata_i[c*DW +: DW]` enters row 0 of column c. After N such cycles, the word presented on the k-th cycle (k = 0 first) sits in row N-1-k.
- R3: A swap (`swap_i` high) after at least N load cycles since reset or the last accepted swap copies all shadow weights to the live weights on that edge. `err_o` stays 0 in the next cycle, and the load count restarts.
- R4: A swap issued after fewer than N load cycles is ignored: the live weights are unchanged, and `err_o` is 1 in the cycle after that edge.
- R5: For a vector a (row r at `act_i[r*DW +: DW]`), column c outputs the signed sum over r of a[r]*w[r][c] on `col_sum_o[c*AW +: AW]`. AW = 2*DW + clog2(N), so no combination of operands overflows.
- R6: A vector accepted on clock edge E is reported for column c in the cycle after edge E+N-1+c, with `col_valid_o[c]` high in that cycle only. Vectors may be accepted on back-to-back cycles, and each one yields one result per column, in order.
- R7: `done_o` is high exactly in the cycle in which column N-1 presents the result of the last vector of a burst, meaning a vector not followed on the next edge by another accepted vector.
- R8: Loading shadow weights while vectors are in flight has no effect on any result until the next accepted swap.
- R9: Load cycles beyond N keep shifting, so the oldest word leaves the bottom row. The load stays complete, and the next swap is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wload_i | input | 1 | Shift one weight word into the shadow registers |
| wdata_i | input | N*DW | Weight word, one signed weight per column |
| swap_i | input | 1 | Make the shadow weights live if the load is complete |
| act_valid_i | input | 1 | Activation vector present |
| act_i | input | N*DW | Activation vector, one signed value per row |
| col_valid_o | output | N | Per-column result valid |
| col_sum_o | output | N*AW | Per-column signed result |
| done_o | output | 1 | Last column emits the final result of a burst |
| err_o | output | 1 | A swap was refused because the load was incomplete |

## Verification
On every cycle, the assertions check that:
- live weights change only on an accepted swap,
- the load counter stays bounded and restarts on a swap,
- an error only follows a swap request,
- column valids ripple from left to right,
- `done_o` coincides with the last column's valid and is followed by a gap.

Only the bench scenarios can show that the numbers are right and on the right cycle. They compare signed dot products, the exact latency per column, the placement of loaded words by row, refused swaps that keep the old weights, shadow loads overlapped with a stream, and extreme operands at full width.

// File: rtl/ws_grid_pkg.sv
package ws_grid_pkg;

  // accumulator wide enough for n products of two dw-bit signed values
  function automatic int acc_width(input int n, input int dw);
    return 2 * dw + $clog2(n);
  endfunction

  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ws_skew_line.sv
module ws_skew_line #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < D; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < D; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[D-1];

endmodule

// File: rtl/ws_load_ctl.sv
module ws_load_ctl
  import ws_grid_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic swap_i,
  output logic swap_en_o,
  output logic err_o
);

  localparam int CW = cnt_width(N);

  logic [CW-1:0] cnt_q;
  logic          full;
  logic          err_q;

  assign full      = (cnt_q == CW'(N));
  assign swap_en_o = swap_i & full;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= swap_i & ~full;
      if (swap_en_o)            cnt_q <= load_i ? CW'(1) : '0;
      else if (load_i && !full) cnt_q <= cnt_q + CW'(1);
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N));

  a_r4_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(swap_i));

  a_r3_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en_o |=> (cnt_q <= CW'(1)));

endmodule

// File: rtl/ws_weight_col.sv
module ws_weight_col #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            swap_en_i,
  output logic [N*DW-1:0] w_o
);

  logic [DW-1:0] shadow_q [N];
  logic [DW-1:0] live_q   [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++) begin
        shadow_q[r] <= '0;
        live_q[r]   <= '0;
      end
    end else begin
      if (load_i) begin
        shadow_q[0] <= wdata_i;
        for (int r = 1; r < N; r++) shadow_q[r] <= shadow_q[r-1];
      end
      if (swap_en_i) begin
        for (int r = 0; r < N; r++) live_q[r] <= shadow_q[r];
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_out
    assign w_o[r*DW +: DW] = live_q[r];
  end

  a_r8_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_en_i |=> $stable(w_o));

endmodule

// File: rtl/ws_mac_pe.sv
module ws_mac_pe #(
  parameter int DW = 8,
  parameter int AW = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [AW-1:0] psum_i,
  output logic signed [AW-1:0] psum_o
);

  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prod_ext;

  assign prod     = a_i * w_i;
  assign prod_ext = {{(AW-2*DW){prod[2*DW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psum_o <= '0;
    else         psum_o <= psum_i + prod_ext;
  end

endmodule

// File: rtl/ws_systolic_grid.sv
module ws_systolic_grid
  import ws_grid_pkg::*;
#(
  parameter  int N  = 4,
  parameter  int DW = 8,
  localparam int AW = acc_width(N, DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wload_i,
  input  logic [N*DW-1:0] wdata_i,
  input  logic            swap_i,
  input  logic            act_valid_i,
  input  logic [N*DW-1:0] act_i,
  output logic [N-1:0]    col_valid_o,
  output logic [N*AW-1:0] col_sum_o,
  output logic            done_o,
  output logic            err_o
);

  logic swap_en;

  ws_load_ctl #(.N(N)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wload_i),
    .swap_i    (swap_i),
    .swap_en_o (swap_en),
    .err_o     (err_o)
  );

  logic signed [DW-1:0] w_live [N][N];  // [row][col]
  logic signed [DW-1:0] a_in   [N][N];
  logic signed [DW-1:0] a_pipe_q [N][N-1];
  logic signed [AW-1:0] ps     [N][N];

  for (genvar c = 0; c < N; c++) begin : g_wcol
    logic [N*DW-1:0] wcol;
    ws_weight_col #(.N(N), .DW(DW)) u_wcol (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (wload_i),
      .wdata_i   (wdata_i[c*DW +: DW]),
      .swap_en_i (swap_en),
      .w_o       (wcol)
    );
    for (genvar r = 0; r < N; r++) begin : g_w
      assign w_live[r][c] = wcol[r*DW +: DW];
    end
  end

  // left-edge skew: row r lags row 0 by r cycles
  for (genvar r = 0; r < N; r++) begin : g_skew
    if (r == 0) begin : g_direct
      assign a_in[0][0] = act_i[DW-1:0];
    end else begin : g_delay
      logic [DW-1:0] skewed;
      ws_skew_line #(.W(DW), .D(r)) u_skew (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (act_i[r*DW +: DW]),
        .q_o    (skewed)
      );
      assign a_in[r][0] = skewed;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N-1; c++) a_pipe_q[r][c] <= '0;
    end else begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N-1; c++) a_pipe_q[r][c] <= a_in[r][c];
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [AW-1:0] ps_top;
      if (c > 0) begin : g_east
        assign a_in[r][c] = a_pipe_q[r][c-1];
      end
      if (r == 0) begin : g_top
        assign ps_top = '0;
      end else begin : g_chain
        assign ps_top = ps[r-1][c];
      end
      ws_mac_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (a_in[r][c]),
        .w_i    (w_live[r][c]),
        .psum_i (ps_top),
        .psum_o (ps[r][c])
      );
    end
  end

  // valid tag rides alongside the bottom row
  logic         v_skew;
  logic [N-1:0] v_in;
  logic [N-2:0] v_pipe_q;
  logic [N-1:0] col_valid_q;

  ws_skew_line #(.W(1), .D(N-1)) u_vskew (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (act_valid_i),
    .q_o    (v_skew)
  );

  assign v_in[0] = v_skew;
  for (genvar c = 1; c < N; c++) begin : g_vin
    assign v_in[c] = v_pipe_q[c-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_pipe_q    <= '0;
      col_valid_q <= '0;
    end else begin
      v_pipe_q    <= v_in[N-2:0];
      col_valid_q <= v_in;
    end
  end

  assign col_valid_o = col_valid_q;
  assign done_o      = col_valid_q[N-1] & ~v_in[N-1];

  for (genvar c = 0; c < N; c++) begin : g_sum
    assign col_sum_o[c*AW +: AW] = ps[N-1][c];
  end

  for (genvar c = 1; c < N; c++) begin : g_ord
    a_r6_col_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_valid_o[c] |-> $past(col_valid_o[c-1]));
  end

  a_r7_done_with_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> col_valid_o[N-1]);

  a_r7_done_then_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !col_valid_o[N-1]);

endmodule

// File: tb/ws_systolic_grid_test.sv
`timescale 1ns/1ps
module ws_systolic_grid_test;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 2*DW + $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wload = 1'b0;
  logic [N*DW-1:0] wdata = '0;
  logic            swap = 1'b0;
  logic            act_valid = 1'b0;
  logic [N*DW-1:0] act = '0;
  logic [N-1:0]    col_valid;
  logic [N*AW-1:0] col_sum;
  logic            done;
  logic            err;

  ws_systolic_grid #(.N(N), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wload_i(wload), .wdata_i(wdata),
    .swap_i(swap), .act_valid_i(act_valid), .act_i(act),
    .col_valid_o(col_valid), .col_sum_o(col_sum), .done_o(done), .err_o(err)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nerr = 0;
  bit finished = 0;
  string cur_req = "R1";

  logic signed [DW-1:0] sh [N][N];
  logic signed [DW-1:0] lw [N][N];
  int ldcnt = 0;

  longint exp_val [N][$];
  int     exp_cyc [N][$];
  int     exp_done [$];

  task automatic chk(input string req, input longint actual, input longint expected);
    nvec++;
    if (actual !== expected) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  function automatic int pat(input int a, input int b, input int seed);
    return ((a*7 + b*13 + seed*31) % 255) - 127;
  endfunction

  function automatic logic [N*DW-1:0] wword(input int row, input int seed, input bit cst, input int cv);
    logic [N*DW-1:0] w;
    for (int c = 0; c < N; c++) w[c*DW +: DW] = DW'(cst ? cv : pat(row, c, seed));
    return w;
  endfunction

  task automatic load_word(input logic [N*DW-1:0] w);
    @(negedge clk);
    wload = 1'b1;
    wdata = w;
    for (int r = N-1; r > 0; r--)
      for (int c = 0; c < N; c++) sh[r][c] = sh[r-1][c];
    for (int c = 0; c < N; c++) sh[0][c] = w[c*DW +: DW];
    if (ldcnt < N) ldcnt++;
  endtask

  task automatic load_end();
    @(negedge clk);
    wload = 1'b0;
  endtask

  // R2: first word ends in the bottom row
  task automatic load_set(input int seed, input bit cst, input int cv);
    for (int k = 0; k < N; k++) load_word(wword(N-1-k, seed, cst, cv));
    load_end();
  endtask

  task automatic do_swap();
    bit ok;
    @(negedge clk);
    swap = 1'b1;
    ok = (ldcnt == N);
    if (ok) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) lw[r][c] = sh[r][c];
      ldcnt = 0;
    end
    @(negedge clk);
    swap = 1'b0;
    chk(ok ? "R3 err_o" : "R4 err_o", longint'(err), ok ? 0 : 1);
  endtask

  task automatic stream(input int m, input int seed, input bit cst, input int cv);
    logic signed [DW-1:0] av [N];
    longint s;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      act_valid = 1'b1;
      for (int r = 0; r < N; r++) begin
        av[r] = DW'(cst ? cv : pat(i, r, seed));
        act[r*DW +: DW] = av[r];
      end
      for (int c = 0; c < N; c++) begin
        s = 0;
        for (int r = 0; r < N; r++) s += longint'(av[r]) * longint'(lw[r][c]);
        exp_val[c].push_back(s);
        exp_cyc[c].push_back(cyc + N + c);
      end
      if (i == m-1) exp_done.push_back(cyc + 2*N - 1);
    end
    @(negedge clk);
    act_valid = 1'b0;
    act = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int c = 0; c < N; c++) begin
        if (col_valid[c]) begin
          if (exp_val[c].size() == 0) begin
            nvec++; nerr++;
            $display("FAIL R6: actual valid on column %0d expected none (cycle %0d)", c, cyc);
          end else begin
            chk(cur_req, longint'($signed(col_sum[c*AW +: AW])), exp_val[c].pop_front());
            chk("R6 latency", cyc, exp_cyc[c].pop_front());
          end
        end
      end
      begin
        bit de;
        de = (exp_done.size() > 0) && (exp_done[0] == cyc);
        if (de) void'(exp_done.pop_front());
        if (de || done) chk("R7 done_o", longint'(done), longint'(de));
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin sh[r][c] = '0; lw[r][c] = '0; end
    idle(3);
    chk("R1 col_valid_o", longint'(col_valid), 0);
    chk("R1 done_o", longint'(done), 0);
    chk("R1 err_o", longint'(err), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 col_valid_o after release", longint'(col_valid), 0);

    cur_req = "R1 zero weights";
    stream(2, 1, 0, 0);
    idle(3*N);

    cur_req = "R2 R5";
    load_set(3, 0, 0);
    do_swap();
    stream(6, 5, 0, 0);
    idle(3*N);

    cur_req = "R4 old weights kept";
    load_word(wword(0, 40, 0, 0));
    load_word(wword(1, 41, 0, 0));
    load_end();
    do_swap();
    stream(3, 7, 0, 0);
    idle(3*N);

    cur_req = "R9 over-length load";
    load_set(9, 0, 0);
    do_swap();
    stream(4, 11, 0, 0);
    idle(3*N);

    cur_req = "R8 shadow load in flight";
    fork
      stream(12, 13, 0, 0);
      begin idle(2); load_set(15, 0, 0); end
    join
    idle(3*N);
    cur_req = "R3 new weights live";
    do_swap();
    stream(5, 17, 0, 0);
    idle(3*N);

    cur_req = "R7 split bursts";
    stream(1, 19, 0, 0);
    idle(1);
    stream(2, 21, 0, 0);
    idle(3*N);

    cur_req = "R5 extreme operands";
    load_set(0, 1, -128);
    do_swap();
    stream(3, 0, 1, -128);
    stream(2, 0, 1, 127);
    idle(3*N);

    for (int c = 0; c < N; c++) chk("R6 outstanding results", exp_val[c].size(), 0);
    chk("R7 outstanding done", exp_done.size(), 0);

    summary();
    $finish;
  end

endmodule